// File: doc/BRIEF.md
# USB Interrupt Status and Mask Bank

This block gathers the event pulses raised by a USB device controller's protocol engine and folds them into one level-sensitive interrupt line for a processor. Events land in three status registers: a 16-bit endpoint transmit register, a 16-bit endpoint receive register and an 8-bit bus-event register. Each status register has an enable register beside it. The interrupt output is high while any status bit is set and its matching enable bit is also set.

The processor reaches the registers through a plain byte-wide register port. A read returns the addressed byte one cycle later and clears the status bits in that byte. Writes go only to the enable registers. A bus-reset event puts both endpoint enable registers back to their defaults, so the control endpoint is the only endpoint left unmasked. Endpoint 0 reports in both directions through bit 0 of the transmit register. For that reason bit 0 of the receive registers is not implemented.

Top module: `usb_irq_bank`

## Requirements
- R1: Out of reset every status register is 0, the transmit enable is 0x0001, the receive and bus enables are 0, and `irq_o` is low.
- R2: A pulse on bit k of `ev_tx_i`, `ev_rx_i` or `ev_bus_i` sets bit k of the matching status register. The bit is set even when its enable bit is clear, and it stays set until a read clears it.
- R3: Byte addresses: 0x2/0x3 transmit status low/high, 0x4/0x5 receive status low/high, 0x6/0x7 transmit enable low/high, 0x8/0x9 receive enable low/high, 0xA bus status, 0xB bus enable. A read presents the addressed byte on `reg_rdata_o` in the cycle after `reg_rd_i` is sampled, and the value holds until the next read.
- R4: A read of a status byte clears that byte, and only that byte, at the same clock edge.
- R5: An event that arrives in the same cycle as a read of its status byte stays pending. The read returns the old contents, and the new bit can be read afterwards.
- R6: `irq_o` is high exactly when some status bit and its enable bit are both set. Setting an enable bit over a pending bit raises `irq_o` in the cycle after the write.
- R7: Bit 0 of the receive status register and bit 0 of the receive enable register always read 0.
- R8: A pulse on `ev_bus_i` bit 2 (bus reset) loads 0x0001 into the transmit enable and 0x0000 into the receive enable. It takes priority over a write to those registers in the same cycle and leaves the bus enable unchanged.
- R9: Writes to status addresses have no effect, and addresses outside the map read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr_i | input | 4 | Byte address of the register access |
| reg_rd_i | input | 1 | Read strobe, one cycle per byte read |
| reg_wr_i | input | 1 | Write strobe, one cycle per byte written |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid in the cycle after the read strobe |
| ev_tx_i | input | 16 | Transmit endpoint event pulses; bit 0 is endpoint 0 in both directions |
| ev_rx_i | input | 16 | Receive endpoint event pulses; bit 0 is ignored |
| ev_bus_i | input | 8 | Bus event pulses: 0 suspend, 1 resume, 2 bus reset, 3 start-of-frame, 4 connect, 5 disconnect, 6 session request, 7 VBUS error |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two pairs of actions can fall on the same clock edge. A read that clears a status byte can meet a new event on that byte. A software write to an endpoint enable can meet a bus-reset event. The bench drives each pair in one cycle. For the first pair it judges the result by the value the read returns and by a second read that must still show the new event. For the second pair it reads back the enable registers, which must hold their defaults. Around these cases, every status bit of every register is swept while masked and unmasked, and the expected read values and interrupt levels are computed arithmetically from the bit index.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;
  localparam int EP_N   = 16;
  localparam int BUS_N  = 8;

  localparam logic [ADDR_W-1:0] A_TX_ST  = 4'h2;
  localparam logic [ADDR_W-1:0] A_RX_ST  = 4'h4;
  localparam logic [ADDR_W-1:0] A_TX_EN  = 4'h6;
  localparam logic [ADDR_W-1:0] A_RX_EN  = 4'h8;
  localparam logic [ADDR_W-1:0] A_BUS_ST = 4'hA;
  localparam logic [ADDR_W-1:0] A_BUS_EN = 4'hB;

  localparam int BUS_RESET_BIT = 2;
endpackage

// File: rtl/usb_irq_status.sv
module usb_irq_status #(
  parameter int           W    = 16,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // set wins over clear so a same-cycle event is kept
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= ((q_o & ~clr_i) | set_i) & LIVE;
  end
endmodule

// File: rtl/usb_irq_enable.sv
module usb_irq_enable #(
  parameter int           W    = 16,
  parameter logic [W-1:0] DFLT = '0,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_dflt_i,
  input  logic [W-1:0] wmask_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)           q_o <= DFLT & LIVE;
    else if (load_dflt_i) q_o <= DFLT & LIVE;
    else                  q_o <= ((q_o & ~wmask_i) | (wdata_i & wmask_i)) & LIVE;
  end
endmodule

// File: rtl/usb_irq_bank.sv
module usb_irq_bank
  import usb_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic [EP_N-1:0]   ev_tx_i,
  input  logic [EP_N-1:0]   ev_rx_i,
  input  logic [BUS_N-1:0]  ev_bus_i,
  output logic              irq_o
);
  localparam logic [EP_N-1:0]  TX_DFLT = EP_N'(1);
  localparam logic [EP_N-1:0]  RX_LIVE = ~EP_N'(1);
  localparam logic [EP_N-1:0]  EP_ALL  = '1;
  localparam logic [BUS_N-1:0] BUS_ALL = '1;

  logic [EP_N-1:0]  tx_st, rx_st, tx_en, rx_en;
  logic [EP_N-1:0]  tx_clr, rx_clr, tx_wm, rx_wm;
  logic [BUS_N-1:0] bus_st, bus_en, bus_clr, bus_wm;
  logic             bus_reset;
  logic [BYTE_W-1:0] rd_byte;

  assign bus_reset = ev_bus_i[BUS_RESET_BIT];

  // per-bit byte-lane decode for the 16-bit registers
  for (genvar i = 0; i < EP_N; i++) begin : g_ep_lane
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(i / BYTE_W);
    assign tx_clr[i] = reg_rd_i && (reg_addr_i == A_TX_ST + OFS);
    assign rx_clr[i] = reg_rd_i && (reg_addr_i == A_RX_ST + OFS);
    assign tx_wm[i]  = reg_wr_i && (reg_addr_i == A_TX_EN + OFS);
    assign rx_wm[i]  = reg_wr_i && (reg_addr_i == A_RX_EN + OFS);
  end

  assign bus_clr = {BUS_N{reg_rd_i && (reg_addr_i == A_BUS_ST)}};
  assign bus_wm  = {BUS_N{reg_wr_i && (reg_addr_i == A_BUS_EN)}};

  usb_irq_status #(.W(EP_N), .LIVE(EP_ALL)) u_tx_st (
    .clk(clk), .rst_n(rst_n), .set_i(ev_tx_i), .clr_i(tx_clr), .q_o(tx_st));
  usb_irq_status #(.W(EP_N), .LIVE(RX_LIVE)) u_rx_st (
    .clk(clk), .rst_n(rst_n), .set_i(ev_rx_i), .clr_i(rx_clr), .q_o(rx_st));
  usb_irq_status #(.W(BUS_N), .LIVE(BUS_ALL)) u_bus_st (
    .clk(clk), .rst_n(rst_n), .set_i(ev_bus_i), .clr_i(bus_clr), .q_o(bus_st));

  usb_irq_enable #(.W(EP_N), .DFLT(TX_DFLT), .LIVE(EP_ALL)) u_tx_en (
    .clk(clk), .rst_n(rst_n), .load_dflt_i(bus_reset), .wmask_i(tx_wm),
    .wdata_i({2{reg_wdata_i}}), .q_o(tx_en));
  usb_irq_enable #(.W(EP_N), .DFLT('0), .LIVE(RX_LIVE)) u_rx_en (
    .clk(clk), .rst_n(rst_n), .load_dflt_i(bus_reset), .wmask_i(rx_wm),
    .wdata_i({2{reg_wdata_i}}), .q_o(rx_en));
  usb_irq_enable #(.W(BUS_N), .DFLT('0), .LIVE(BUS_ALL)) u_bus_en (
    .clk(clk), .rst_n(rst_n), .load_dflt_i(1'b0), .wmask_i(bus_wm),
    .wdata_i(reg_wdata_i), .q_o(bus_en));

  always_comb begin
    unique case (reg_addr_i)
      A_TX_ST:         rd_byte = tx_st[7:0];
      A_TX_ST + 4'h1:  rd_byte = tx_st[15:8];
      A_RX_ST:         rd_byte = rx_st[7:0];
      A_RX_ST + 4'h1:  rd_byte = rx_st[15:8];
      A_TX_EN:         rd_byte = tx_en[7:0];
      A_TX_EN + 4'h1:  rd_byte = tx_en[15:8];
      A_RX_EN:         rd_byte = rx_en[7:0];
      A_RX_EN + 4'h1:  rd_byte = rx_en[15:8];
      A_BUS_ST:        rd_byte = bus_st;
      A_BUS_EN:        rd_byte = bus_en;
      default:         rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_byte;
  end

  assign irq_o = |(tx_st & tx_en) | |(rx_st & rx_en) | |(bus_st & bus_en);
endmodule

module usb_irq_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  reg_addr_i,
  input logic        reg_rd_i,
  input logic        reg_wr_i,
  input logic [15:0] ev_tx_i,
  input logic [7:0]  ev_bus_i,
  input logic [15:0] tx_st,
  input logic [15:0] rx_st,
  input logic [7:0]  bus_st,
  input logic [15:0] tx_en,
  input logic [15:0] rx_en,
  input logic        irq_o
);
  a_r2_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_i != 16'h0) |=> ((tx_st & $past(ev_tx_i)) == $past(ev_tx_i)));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_addr_i == 4'hA && ev_bus_i == 8'h0) |=> (bus_st == 8'h0));

  a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_addr_i == 4'hA) |=> (bus_st == $past(ev_bus_i)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !reg_rd_i && !reg_wr_i && !ev_bus_i[2]) |=> irq_o);

  a_r7_rx0: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_st[0] && !rx_en[0]));

  a_r8_busrst: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_i[2] |=> (tx_en == 16'h0001 && rx_en == 16'h0000));
endmodule

bind usb_irq_bank usb_irq_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr_i), .reg_rd_i(reg_rd_i),
  .reg_wr_i(reg_wr_i), .ev_tx_i(ev_tx_i), .ev_bus_i(ev_bus_i),
  .tx_st(tx_st), .rx_st(rx_st), .bus_st(bus_st), .tx_en(tx_en),
  .rx_en(rx_en), .irq_o(irq_o));

// File: tb/usb_irq_bank_test.sv
`timescale 1ns/1ps
module usb_irq_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] ev_tx = '0, ev_rx = '0;
  logic [7:0]  ev_bus = '0;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  logic [7:0]  d;

  always #2.5 clk = ~clk;

  usb_irq_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ev_tx_i(ev_tx), .ev_rx_i(ev_rx),
    .ev_bus_i(ev_bus), .irq_o(irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic rd_b(input logic [3:0] a, output logic [7:0] v);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    v = rdata;
  endtask

  task automatic wr_b(input logic [3:0] a, input logic [7:0] v);
    addr = a; wdata = v; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] t, input logic [15:0] r, input logic [7:0] b);
    ev_tx = t; ev_rx = r; ev_bus = b;
    @(negedge clk);
    ev_tx = '0; ev_rx = '0; ev_bus = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual %h expected %h", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R3 map, R9 unmapped addresses
    chk("R1 irq", 16'(irq), 16'h0);
    for (int a = 0; a < 16; a++) begin
      rd_b(4'(a), d);
      chk(a == 6 ? "R1 txen" : "R1/R9 reset read", 16'(d), (a == 6) ? 16'h1 : 16'h0);
    end

    // R2/R4/R6 transmit sweep with only endpoint 0 enabled
    for (int b = 0; b < 16; b++) begin
      logic [15:0] m;
      m = 16'(1) << b;
      pulse(m, '0, '0);
      chk("R6 tx irq", 16'(irq), 16'(b == 0));
      rd_b(4'h2, d); chk("R2 tx lo", 16'(d), m & 16'hFF);
      rd_b(4'h3, d); chk("R2 tx hi", 16'(d), m >> 8);
      rd_b(4'h2, d); chk("R4 tx lo clr", 16'(d), 16'h0);
      rd_b(4'h3, d); chk("R4 tx hi clr", 16'(d), 16'h0);
      chk("R6 tx irq low", 16'(irq), 16'h0);
    end

    // R4 byte-only clear
    pulse(16'h0101, '0, '0);
    rd_b(4'h2, d);
    rd_b(4'h3, d); chk("R4 other byte kept", 16'(d), 16'h01);

    // R7 receive enable bit 0 not implemented
    wr_b(4'h8, 8'hFF); wr_b(4'h9, 8'hFF);
    rd_b(4'h8, d); chk("R7 rxen lo", 16'(d), 16'hFE);
    rd_b(4'h9, d); chk("R3 rxen hi", 16'(d), 16'hFF);

    for (int b = 0; b < 16; b++) begin
      logic [15:0] m;
      m = (b == 0) ? 16'h0 : (16'(1) << b);
      pulse('0, 16'(1) << b, '0);
      chk("R7 rx irq", 16'(irq), 16'(b != 0));
      rd_b(4'h4, d); chk("R7 rx lo", 16'(d), m & 16'hFF);
      rd_b(4'h5, d); chk("R2 rx hi", 16'(d), m >> 8);
      chk("R6 rx irq low", 16'(irq), 16'h0);
    end

    // R9 writes to status are ignored
    pulse(16'h0000, '0, 8'h01);
    wr_b(4'hA, 8'h00);
    wr_b(4'h2, 8'hFF);
    rd_b(4'h2, d); chk("R9 tx st write", 16'(d), 16'h0);
    rd_b(4'hA, d); chk("R9 bus st write", 16'(d), 16'h01);

    // bus sweep: masked latch, late enable raises irq (R6), bus reset (R8)
    wr_b(4'h6, 8'hFF); wr_b(4'h7, 8'hFF);
    for (int b = 0; b < 8; b++) begin
      logic [7:0] m;
      m = 8'(1) << b;
      pulse('0, '0, m);
      chk("R2 bus masked irq", 16'(irq), 16'h0);
      wr_b(4'hB, m);
      chk("R6 late enable", 16'(irq), 16'h1);
      rd_b(4'hA, d); chk("R2 bus st", 16'(d), 16'(m));
      chk("R6 irq after read", 16'(irq), 16'h0);
      wr_b(4'hB, 8'h00);
      if (b == 2) begin
        rd_b(4'h6, d); chk("R8 txen lo", 16'(d), 16'h01);
        rd_b(4'h7, d); chk("R8 txen hi", 16'(d), 16'h00);
        rd_b(4'h8, d); chk("R8 rxen lo", 16'(d), 16'h00);
        rd_b(4'h9, d); chk("R8 rxen hi", 16'(d), 16'h00);
      end
    end

    // R8 bus reset beats a same-cycle write; bus enable untouched
    wr_b(4'hB, 8'h80);
    addr = 4'h7; wdata = 8'hAA; wr = 1'b1; ev_bus = 8'h04;
    @(negedge clk);
    wr = 1'b0; ev_bus = '0;
    rd_b(4'h7, d); chk("R8 priority", 16'(d), 16'h00);
    rd_b(4'hB, d); chk("R8 bus en kept", 16'(d), 16'h80);
    rd_b(4'hA, d);

    // R5 event in the same cycle as the read of its byte
    pulse('0, '0, 8'h01);
    addr = 4'hA; rd = 1'b1; ev_bus = 8'h02;
    @(negedge clk);
    rd = 1'b0; ev_bus = '0;
    chk("R5 old value", 16'(rdata), 16'h01);
    rd_b(4'hA, d); chk("R5 new kept", 16'(d), 16'h02);

    pulse(16'h0001, '0, '0);
    addr = 4'h2; rd = 1'b1; ev_tx = 16'h0001;
    @(negedge clk);
    rd = 1'b0; ev_tx = '0;
    chk("R5 tx irq kept", 16'(irq), 16'h1);
    rd_b(4'h2, d); chk("R5 tx kept", 16'(d), 16'h01);

    summary();
  end
endmodule